// File: doc/BRIEF.md
# Dual Wiper Serial Command Controller

This block is the serial command front end for two 10-bit wiper position registers, called wiper A and wiper B. A host sends 24-bit frames over a four-wire serial link made of chip select, clock, data in and data out. The block runs on the chip's own clock. It brings the serial pins into that clock domain through two-flop synchronisers and finds the clock and chip-select edges by comparing each sample with the one before.

A small frame state machine has three states:
- `FS_IDLE` waits for chip select to go low.
- `FS_SHIFT` shifts one data-in bit per rising serial clock and counts the bits.
- `FS_EXEC` lasts one cycle and is where the command is applied.

The transitions are:
- `FS_IDLE` to `FS_SHIFT` when chip select is seen low. The bit count is cleared on entry.
- `FS_SHIFT` to `FS_EXEC` when chip select is seen high and exactly 24 bits were counted.
- `FS_SHIFT` to `FS_IDLE` when chip select is seen high with any other count. The frame is dropped.
- `FS_EXEC` to `FS_IDLE` always.

The frame layout is: command in bits [23:20], address in bits [19:16], bits [15:10] ignored, and data in bits [9:0]. The commands are:
- Direct load, no-operation.
- Step up or step down by one, on the addressed wiper or on both wipers.
- Doubling or halving, on the addressed wiper or on both wipers.
- Two readback forms.
- Store and restore requests. These are forwarded as one-cycle pulses with a wiper mask to a separate nonvolatile-memory sequencer.

Data out normally repeats the previous frame, so devices can be daisy-chained. A readback frame instead loads a word holding the wiper codes, which is shifted out during the next frame. An active-low write-protect input blocks every wiper change and every store request.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: Data in is sampled on rising serial-clock edges, most significant bit first. A frame is acted on only after chip select returns high. While a frame is being shifted, the wipers do not change. When no frame completes, the wipers do not change.
- R2: A frame whose bit count is not exactly 24 when chip select rises is discarded. It changes no wiper and raises no request.
- R3: After reset, both wipers hold 512, data out is 0, and no store or restore pulse is present.
- R4: Address 0 selects wiper A and address 1 selects wiper B. An addressed command with any other address has no effect.
- R5: Command 0xB loads data bits [9:0] into the addressed wiper. Command 0x0 changes nothing.
- R6: Step commands saturate at 1023 going up and at 0 going down. The codes are:
  - 0x4 adds one to the addressed wiper.
  - 0x5 adds one to both wipers.
  - 0x6 subtracts one from the addressed wiper.
  - 0x7 subtracts one from both wipers.
- R7: Doubling and halving commands work as follows. Doubling a code of 512 or more gives 1023. Halving truncates toward zero. The codes are:
  - 0xE doubles the addressed wiper.
  - 0xF doubles both wipers.
  - 0xC halves the addressed wiper.
  - 0xD halves both wipers.
- R8: After any frame that is not a readback frame, the next frame shifts out on data out the 24 bits of that frame, most significant bit first. The bit is valid before each rising serial-clock edge.
- R9: Readback frames set what the next frame shifts out:
  - After command 0x9 with address 0 or 1, the next frame shifts out {4'h9, address, 6'b0, code of the addressed wiper}.
  - After command 0xA, the next frame shifts out {4'hA, code of wiper B, code of wiper A}.
- R10: While write-protect is low, no command changes either wiper and no store pulse is issued. Restore and readback still operate.
- R11: Store and restore requests are single-cycle pulses with a mask, where bit 0 means wiper A and bit 1 means wiper B. The codes are:
  - 0x2 stores the addressed wiper.
  - 0x3 stores both wipers.
  - 0x1 restores the addressed wiper.
  - 0x8 restores both wipers.
  
  A store pulse and a restore pulse never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low asynchronous reset |
| spi_sclk | input | 1 | serial clock from the host |
| spi_cs_n | input | 1 | active-low frame select |
| spi_mosi | input | 1 | serial data in |
| spi_miso | output | 1 | serial data out (echo or readback) |
| wp_n | input | 1 | active-low write protect |
| wiper_a | output | 10 | wiper A code |
| wiper_b | output | 10 | wiper B code |
| nv_store | output | 1 | store request pulse |
| nv_restore | output | 1 | restore request pulse |
| nv_sel | output | 2 | wiper mask of the request |

## Verification
A wrong state here shows up at the ports within one frame.
- A bad wiper code appears on `wiper_a` or `wiper_b` a few clocks after chip select rises.
- A corrupted shift register or bit count shows in the echoed or readback word, which is shifted out during the very next frame.

The bench sweeps wiper codes across the whole range for load, doubling and halving, and computes each expected value arithmetically. It then targets the saturation edges, bad frame lengths, illegal addresses and write protection.

// File: rtl/dw_pkg.sv
package dw_pkg;
    localparam int FRAME_BITS = 24;
    localparam int CMD_W      = 4;
    localparam int ADR_W      = 4;

    typedef enum logic [1:0] {FS_IDLE, FS_SHIFT, FS_EXEC} frame_state_e;

    typedef enum logic [2:0] {
        W_HOLD, W_LOAD, W_INC, W_DEC, W_DBL, W_HALF
    } wiper_op_e;

    localparam logic [3:0] C_NOP      = 4'h0;
    localparam logic [3:0] C_RST_ONE  = 4'h1;
    localparam logic [3:0] C_STO_ONE  = 4'h2;
    localparam logic [3:0] C_STO_ALL  = 4'h3;
    localparam logic [3:0] C_INC_ONE  = 4'h4;
    localparam logic [3:0] C_INC_ALL  = 4'h5;
    localparam logic [3:0] C_DEC_ONE  = 4'h6;
    localparam logic [3:0] C_DEC_ALL  = 4'h7;
    localparam logic [3:0] C_RST_ALL  = 4'h8;
    localparam logic [3:0] C_RD_ONE   = 4'h9;
    localparam logic [3:0] C_RD_ALL   = 4'hA;
    localparam logic [3:0] C_LOAD     = 4'hB;
    localparam logic [3:0] C_HALF_ONE = 4'hC;
    localparam logic [3:0] C_HALF_ALL = 4'hD;
    localparam logic [3:0] C_DBL_ONE  = 4'hE;
    localparam logic [3:0] C_DBL_ALL  = 4'hF;
endpackage

// File: rtl/dw_sync.sv
module dw_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/dw_frame_fsm.sv
module dw_frame_fsm
    import dw_pkg::*;
#(
    parameter int FB = FRAME_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    input  logic          load_en,
    input  logic [FB-1:0] load_word,
    output logic          exec,
    output logic [FB-1:0] frame,
    output logic          miso
);
    localparam int CW = $clog2(FB) + 1;

    frame_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [FB-1:0] sh_q;
    logic          sclk_d;
    logic          sclk_rise;

    assign sclk_rise = sclk_s && !sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (!cs_n_s) state_d = FS_SHIFT;
            FS_SHIFT: if (cs_n_s)  state_d = (cnt_q == CW'(FB)) ? FS_EXEC : FS_IDLE;
            FS_EXEC:  state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    always_comb begin
        exec  = (state_q == FS_EXEC);
        frame = sh_q;
        miso  = sh_q[FB-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (state_q == FS_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == FS_SHIFT && !cs_n_s == 1'b1 && sclk_rise) begin
                sh_q <= {sh_q[FB-2:0], mosi_s};
                if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end else if (state_q == FS_EXEC && load_en) begin
                sh_q <= load_word;
            end
        end
    end

    p_exec_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        exec |-> cs_n_s);
    p_exec_from_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_SHIFT && cs_n_s && cnt_q != CW'(FB)) |=> !exec);
endmodule

// File: rtl/dw_wiper_unit.sv
module dw_wiper_unit
    import dw_pkg::*;
#(
    parameter int              CODE_W    = 10,
    parameter logic [CODE_W-1:0] RST_CODE = CODE_W'(1 << (CODE_W - 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  wiper_op_e         op,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] TOP = '1;

    logic [CODE_W-1:0] code_q, code_d;

    always_comb begin
        code_d = code_q;
        unique case (op)
            W_LOAD:  code_d = data;
            W_INC:   code_d = (code_q == TOP) ? TOP : code_q + 1'b1;
            W_DEC:   code_d = (code_q == '0) ? '0 : code_q - 1'b1;
            W_DBL:   code_d = code_q[CODE_W-1] ? TOP : {code_q[CODE_W-2:0], 1'b0};
            W_HALF:  code_d = {1'b0, code_q[CODE_W-1:1]};
            default: code_d = code_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  code_q <= RST_CODE;
        else if (en) code_q <= code_d;
    end

    assign code = code_q;

    p_hold_without_exec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(code_q));
    p_step_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == W_INC || op == W_DEC)) |=>
        ((code_q - $past(code_q)) == CODE_W'(1) ||
         ($past(code_q) - code_q) == CODE_W'(1) || $stable(code_q)));
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import dw_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              wp_n,
    output logic [CODE_W-1:0] wiper_a,
    output logic [CODE_W-1:0] wiper_b,
    output logic              nv_store,
    output logic              nv_restore,
    output logic [1:0]        nv_sel
);
    localparam int PAD_W = FRAME_BITS - CMD_W - ADR_W - CODE_W;

    logic [2:0] pins_s;
    logic       exec;
    logic [FRAME_BITS-1:0] frame, rd_word;
    logic       rd_en;
    logic [CMD_W-1:0] cmd;
    logic [ADR_W-1:0] adr;
    logic [CODE_W-1:0] dat, sel_code;
    logic [1:0] adr_mask, op_mask, sto_mask, rst_mask;
    wiper_op_e  op;
    logic [CODE_W-1:0] codes [2];

    dw_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_mosi, spi_cs_n, spi_sclk}), .q(pins_s)
    );

    dw_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[0]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[2]),
        .load_en(rd_en), .load_word(rd_word),
        .exec(exec), .frame(frame), .miso(spi_miso)
    );

    assign cmd = frame[FRAME_BITS-1 -: CMD_W];
    assign adr = frame[FRAME_BITS-CMD_W-1 -: ADR_W];
    assign dat = frame[CODE_W-1:0];
    assign adr_mask = (adr == ADR_W'(0)) ? 2'b01 :
                      (adr == ADR_W'(1)) ? 2'b10 : 2'b00;
    assign sel_code = adr_mask[1] ? codes[1] : codes[0];

    always_comb begin
        op       = W_HOLD;
        op_mask  = 2'b00;
        sto_mask = 2'b00;
        rst_mask = 2'b00;
        rd_en    = 1'b0;
        rd_word  = frame;
        unique case (cmd)
            C_RST_ONE:  rst_mask = adr_mask;
            C_RST_ALL:  rst_mask = 2'b11;
            C_STO_ONE:  sto_mask = adr_mask;
            C_STO_ALL:  sto_mask = 2'b11;
            C_INC_ONE:  begin op = W_INC;  op_mask = adr_mask; end
            C_INC_ALL:  begin op = W_INC;  op_mask = 2'b11;    end
            C_DEC_ONE:  begin op = W_DEC;  op_mask = adr_mask; end
            C_DEC_ALL:  begin op = W_DEC;  op_mask = 2'b11;    end
            C_LOAD:     begin op = W_LOAD; op_mask = adr_mask; end
            C_HALF_ONE: begin op = W_HALF; op_mask = adr_mask; end
            C_HALF_ALL: begin op = W_HALF; op_mask = 2'b11;    end
            C_DBL_ONE:  begin op = W_DBL;  op_mask = adr_mask; end
            C_DBL_ALL:  begin op = W_DBL;  op_mask = 2'b11;    end
            C_RD_ONE: begin
                rd_en   = exec && (adr_mask != 2'b00);
                rd_word = {cmd, adr, {PAD_W{1'b0}}, sel_code};
            end
            C_RD_ALL: begin
                rd_en   = exec;
                rd_word = {cmd, {(FRAME_BITS-CMD_W-2*CODE_W){1'b0}}, codes[1], codes[0]};
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < 2; i++) begin : g_wiper
        dw_wiper_unit #(.CODE_W(CODE_W)) u_wiper (
            .clk(clk), .rst_n(rst_n),
            .en(exec && wp_n && op_mask[i]),
            .op(op), .data(dat), .code(codes[i])
        );
    end

    assign wiper_a = codes[0];
    assign wiper_b = codes[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_store   <= 1'b0;
            nv_restore <= 1'b0;
            nv_sel     <= 2'b00;
        end else begin
            nv_store   <= exec && wp_n && (sto_mask != 2'b00);
            nv_restore <= exec && (rst_mask != 2'b00);
            nv_sel     <= exec ? (sto_mask | rst_mask) : 2'b00;
        end
    end

    p_wp_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> ($stable(wiper_a) && $stable(wiper_b)));
    p_wp_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !nv_store);
    p_req_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_store && nv_restore));
    p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_store || nv_restore) |=> !(nv_store || nv_restore));
endmodule

// File: tb/dual_wiper_ctrl_bench.sv
module dual_wiper_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso, st, rs;
    logic [9:0] wa, wb;
    logic [1:0] sel;
    int total = 0, bad = 0;
    int st_cnt = 0, rs_cnt = 0;
    logic [1:0] last_sel = 2'b00;
    logic [23:0] got;

    always #5 clk = ~clk;

    dual_wiper_ctrl u_dual_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n),
        .wiper_a(wa), .wiper_b(wb), .nv_store(st), .nv_restore(rs), .nv_sel(sel)
    );

    always @(posedge clk) begin
        if (st) begin st_cnt <= st_cnt + 1; last_sel <= sel; end
        if (rs) begin rs_cnt <= rs_cnt + 1; last_sel <= sel; end
    end

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] fr(input logic [3:0] c, input logic [3:0] a, input logic [9:0] d);
        return {c, a, 6'b0, d};
    endfunction

    task automatic send(input logic [23:0] w, input int nbits, output logic [23:0] rx);
        rx = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (nbits - 1 - i < 24) ? w[23 - i] : 1'b0;
            repeat (5) @(negedge clk);
            rx = {rx[22:0], miso};
            sclk = 1'b1;
            repeat (5) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic put(input logic [23:0] w);
        logic [23:0] dummy;
        send(w, 24, dummy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int sc, rc;
        logic [9:0] k, ea, eb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R3 reset state
        chk("R3 wiper_a", 24'(wa), 24'd512);
        chk("R3 wiper_b", 24'(wb), 24'd512);
        chk("R3 miso", 24'(miso), 24'd0);
        chk("R3 pulses", 24'(st_cnt + rs_cnt), 24'd0);

        // R4 R5 addressed loads
        put(fr(4'hB, 4'h0, 10'h155));
        send(fr(4'hB, 4'h1, 10'h2AA), 24, got);
        chk("R8 echo of previous frame", got, fr(4'hB, 4'h0, 10'h155));
        chk("R4 R5 load wiper A", 24'(wa), 24'h155);
        chk("R4 R5 load wiper B", 24'(wb), 24'h2AA);
        put(fr(4'hB, 4'h3, 10'h001));
        chk("R4 illegal address A", 24'(wa), 24'h155);
        chk("R4 illegal address B", 24'(wb), 24'h2AA);
        put(fr(4'h0, 4'h0, 10'h000));
        chk("R5 nop A", 24'(wa), 24'h155);
        chk("R5 nop B", 24'(wb), 24'h2AA);

        // R7 sweep of doubling and halving
        for (int v = 0; v < 1024; v += 31) begin
            k = 10'(v);
            put(fr(4'hB, 4'h0, k));
            chk("R5 sweep load", 24'(wa), 24'(k));
            put(fr(4'hE, 4'h0, 10'h0));
            chk("R7 double", 24'(wa), (v >= 512) ? 24'd1023 : 24'(2 * v));
            put(fr(4'hB, 4'h1, k));
            put(fr(4'hC, 4'h1, 10'h0));
            chk("R7 halve", 24'(wb), 24'(v / 2));
        end

        // R6 saturation
        put(fr(4'hB, 4'h0, 10'd1022));
        put(fr(4'h4, 4'h0, 10'h0));
        chk("R6 inc to top", 24'(wa), 24'd1023);
        put(fr(4'h4, 4'h0, 10'h0));
        chk("R6 inc saturates", 24'(wa), 24'd1023);
        put(fr(4'hB, 4'h1, 10'd1));
        put(fr(4'h6, 4'h1, 10'h0));
        chk("R6 dec to zero", 24'(wb), 24'd0);
        put(fr(4'h6, 4'h1, 10'h0));
        chk("R6 dec saturates", 24'(wb), 24'd0);
        put(fr(4'hB, 4'h0, 10'd100));
        put(fr(4'hB, 4'h1, 10'd1023));
        put(fr(4'h5, 4'h0, 10'h0));
        chk("R6 inc both A", 24'(wa), 24'd101);
        chk("R6 inc both B", 24'(wb), 24'd1023);
        put(fr(4'h7, 4'h0, 10'h0));
        chk("R6 dec both A", 24'(wa), 24'd100);
        chk("R6 dec both B", 24'(wb), 24'd1022);
        put(fr(4'hF, 4'h0, 10'h0));
        chk("R7 double both A", 24'(wa), 24'd200);
        chk("R7 double both B", 24'(wb), 24'd1023);
        put(fr(4'hD, 4'h0, 10'h0));
        chk("R7 halve both A", 24'(wa), 24'd100);
        chk("R7 halve both B", 24'(wb), 24'd511);

        // R9 readback
        put(fr(4'h9, 4'h1, 10'h0));
        send(fr(4'hA, 4'h0, 10'h0), 24, got);
        chk("R9 read one", got, {4'h9, 4'h1, 6'b0, 10'd511});
        send(fr(4'h0, 4'h0, 10'h0), 24, got);
        chk("R9 read both", got, {4'hA, 10'd511, 10'd100});

        // R2 bad lengths
        put(fr(4'hB, 4'h0, 10'd7));
        chk("R1 full frame applied", 24'(wa), 24'd7);
        send(fr(4'hB, 4'h0, 10'd9), 23, got);
        chk("R2 short frame", 24'(wa), 24'd7);
        send(fr(4'hB, 4'h0, 10'd9), 25, got);
        chk("R2 long frame", 24'(wa), 24'd7);
        sc = st_cnt;
        send(fr(4'h3, 4'h0, 10'h0), 23, got);
        chk("R2 short frame no request", 24'(st_cnt), 24'(sc));

        // R11 requests
        sc = st_cnt; rc = rs_cnt;
        put(fr(4'h2, 4'h1, 10'h0));
        chk("R11 store one count", 24'(st_cnt), 24'(sc + 1));
        chk("R11 store one mask", 24'(last_sel), 24'b10);
        put(fr(4'h3, 4'h0, 10'h0));
        chk("R11 store all mask", 24'(last_sel), 24'b11);
        put(fr(4'h1, 4'h0, 10'h0));
        chk("R11 restore one count", 24'(rs_cnt), 24'(rc + 1));
        chk("R11 restore one mask", 24'(last_sel), 24'b01);
        put(fr(4'h8, 4'h0, 10'h0));
        chk("R11 restore all mask", 24'(last_sel), 24'b11);
        chk("R11 store total", 24'(st_cnt), 24'(sc + 2));

        // R10 write protect
        ea = wa; eb = wb;
        wp_n = 1'b0;
        sc = st_cnt; rc = rs_cnt;
        put(fr(4'hB, 4'h0, 10'd333));
        put(fr(4'h5, 4'h0, 10'h0));
        put(fr(4'hF, 4'h0, 10'h0));
        chk("R10 protected A", 24'(wa), 24'(ea));
        chk("R10 protected B", 24'(wb), 24'(eb));
        put(fr(4'h3, 4'h0, 10'h0));
        chk("R10 store blocked", 24'(st_cnt), 24'(sc));
        put(fr(4'h8, 4'h0, 10'h0));
        chk("R10 restore allowed", 24'(rs_cnt), 24'(rc + 1));
        put(fr(4'hA, 4'h0, 10'h0));
        send(fr(4'h0, 4'h0, 10'h0), 24, got);
        chk("R10 readback allowed", got, {4'hA, eb, ea});
        wp_n = 1'b1;
        put(fr(4'hB, 4'h0, 10'd333));
        chk("R10 unprotected load", 24'(wa), 24'd333);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule